// File: doc/BRIEF.md
# Collision-Detecting Half-Duplex UART Node

This block is one node of a shared serial line on which several equal peers transmit. The line is wired-AND: any node that pulls it low wins over nodes that leave it released, so low is dominant and high is recessive. Each frame is one start bit, eight data bits, a parity bit and a stop bit, and every bit lasts a fixed number of clock cycles set by a parameter.

While the node sends, it reads the line back. At the middle of each bit it compares what it reads with what it sent. If it sent a recessive bit but reads a dominant one, another node has taken the line. The node then releases its driver for the rest of the frame and reports that it lost. A node that sends a dominant bit cannot lose that bit, so the node that wins arbitration finishes its frame without a break. The receiver decodes every frame on the line: the node's own frames, frames from other nodes, and frames that beat the node in arbitration. It rejects a short low spike instead of taking it as a start bit. Transmission is held off while the receiver is busy with a frame. After each own frame or lost arbitration, transmission also waits for one bit time of idle line.

The block is meant to sit behind a small controller that hands it bytes and decides whether to retry after a loss. Retry and backoff are not part of this block.

Top module: `cdu_node`

## Requirements
- R1: A byte accepted for sending goes out as one low start bit, the eight data bits least significant first, a parity bit, and a high stop bit. Each bit lasts CLKS_PER_BIT cycles. `line_drive_low`=1 pulls the line low and 0 releases it.
- R2: With ODD_PARITY=0 (the default), the parity bit makes the number of ones across the data and parity bits even. With ODD_PARITY=1 it makes that number odd.
- R3: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. When the stop bit of a frame ends without a loss, `done_pulse` is high for one cycle. `done_pulse` and `lost_pulse` are never high together.
- R4: If the node sends a high bit and the line reads low at mid-bit, `lost_pulse` is high for one cycle and `line_drive_low` stays 0 for the rest of the frame. No `done_pulse` follows for that frame.
- R5: A node that sends a low bit while another node sends a high bit does not raise `lost_pulse`. It completes its frame and gives `done_pulse`.
- R6: While the receiver is decoding a frame from another node, `tx_ready` is low. A held `tx_valid` then causes no drive on the line.
- R7: A low pulse on the line shorter than half a bit produces no received byte. Afterwards `tx_ready` returns high.
- R8: Every frame on the line, including the node's own frames, gives a one-cycle `rx_valid` with the data bits on `rx_data`.
- R9: `rx_parity_err` goes high together with `rx_valid` when the received parity bit does not match the parity rule of R2.
- R10: After an own frame ends or is lost, `tx_ready` stays low until the line has been high for CLKS_PER_BIT consecutive cycles.
- R11: After reset, the line is released, no pulse output is high, and `tx_ready` is high while the line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Send request |
| tx_ready | output | 1 | The node can accept a byte |
| line_in | input | 1 | Level read from the shared line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_parity_err | output | 1 | Parity mismatch for the strobed byte |
| lost_pulse | output | 1 | One-cycle strobe: arbitration was lost |
| done_pulse | output | 1 | One-cycle strobe: own frame completed |

## Verification
The bench models the wired-AND line together with a scripted peer.

- **Simultaneous start, node sends a one first.** The peer starts in the same cycle as the node and sends a zero in the first data bit. A design that checks at the wrong point, or that does not release its driver, either keeps sending or reports completion.
- **Node sends the dominant bit.** In the reverse case the node must finish without a loss flag. A design that treats any mismatch as a loss fails here.
- **Short spike.** A spike shorter than half a bit must leave no byte behind. A receiver without the mid-start recheck produces a byte of all ones.
- **Request during a foreign frame.** A request held during another node's frame must not reach the line.
- **Idle wait and parity.** The idle wait after a frame and the parity sense are checked on the node's own frames, with one byte of each parity. A received frame with a corrupted parity bit is also checked.

// File: rtl/cdu_pkg.sv
package cdu_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 3;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_COOL} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
endpackage

// File: rtl/cdu_sync.sv
module cdu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cdu_rx.sv
module cdu_rx
  import cdu_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter bit ODD_PARITY   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_s,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_parity_err,
  output logic                 rx_busy
);
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int IW   = $clog2(DATA_BITS + 2);

  rx_state_t            state;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS:0]   shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RX_IDLE;
      cnt           <= '0;
      idx           <= '0;
      shreg         <= '0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!line_s) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            idx <= '0;
            // spike rejection: line back high at mid-start
            state <= line_s ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            if (idx == IW'(DATA_BITS + 1)) begin
              rx_valid      <= 1'b1;
              rx_data       <= shreg[DATA_BITS-1:0];
              rx_parity_err <= (^shreg) ^ ODD_PARITY;
              state         <= RX_IDLE;
            end else begin
              shreg <= {line_s, shreg[DATA_BITS:1]};
              idx   <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign rx_busy = (state != RX_IDLE);

  // R8
  rx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7
  rx_after_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> (state == RX_IDLE) && $past(state == RX_BITS));
endmodule

// File: rtl/cdu_tx.sv
module cdu_tx
  import cdu_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter bit ODD_PARITY   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 line_s,
  input  logic                 rx_busy,
  output logic                 drive_low,
  output logic                 lost_pulse,
  output logic                 done_pulse
);
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int IW   = $clog2(FRAME_BITS);

  tx_state_t             state;
  logic [CW-1:0]         cnt;
  logic [IW-1:0]         idx;
  logic [FRAME_BITS-1:0] shreg;
  logic                  par_bit;

  assign par_bit  = (^tx_data) ^ ODD_PARITY;
  assign tx_ready = (state == TX_IDLE) && !rx_busy && line_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '1;
      drive_low  <= 1'b0;
      lost_pulse <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      lost_pulse <= 1'b0;
      done_pulse <= 1'b0;
      case (state)
        TX_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (tx_valid && tx_ready) begin
            shreg     <= {1'b1, par_bit, tx_data, 1'b0};
            drive_low <= 1'b1;
            state     <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (cnt == CW'(HALF) && shreg[0] && !line_s) begin
            // recessive sent, dominant read: arbitration lost
            lost_pulse <= 1'b1;
            drive_low  <= 1'b0;
            cnt        <= '0;
            state      <= TX_COOL;
          end else if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            if (idx == IW'(FRAME_BITS - 1)) begin
              done_pulse <= 1'b1;
              drive_low  <= 1'b0;
              state      <= TX_COOL;
            end else begin
              idx       <= idx + 1'b1;
              shreg     <= {1'b1, shreg[FRAME_BITS-1:1]};
              drive_low <= ~shreg[1];
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_COOL: begin
          if (!line_s)                           cnt <= '0;
          else if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end else                               cnt <= cnt + 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R4
  lost_release_chk: assert property (@(posedge clk) disable iff (rst)
    lost_pulse |=> !drive_low);

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lost_pulse && done_pulse));

  // R5
  lost_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    lost_pulse |-> !$past(line_s));
endmodule

// File: rtl/cdu_node.sv
module cdu_node
  import cdu_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter bit ODD_PARITY   = 1'b0,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_parity_err,
  output logic       lost_pulse,
  output logic       done_pulse
);
  logic line_s;
  logic rx_busy;

  cdu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(line_in), .dout(line_s)
  );

  cdu_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .ODD_PARITY(ODD_PARITY)) u_rx (
    .clk(clk), .rst(rst), .line_s(line_s),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_busy(rx_busy)
  );

  cdu_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .ODD_PARITY(ODD_PARITY)) u_tx (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .line_s(line_s), .rx_busy(rx_busy),
    .drive_low(line_drive_low), .lost_pulse(lost_pulse),
    .done_pulse(done_pulse)
  );

  // R6
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !rx_busy);
endmodule

// File: tb/cdu_node_tb.sv
module cdu_node_tb;
  localparam int BIT = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       peer_low = 1'b0;
  logic       tx_ready, line_drive_low, rx_valid, rx_parity_err;
  logic       lost_pulse, done_pulse;
  logic [7:0] rx_data;
  logic       line;

  int total = 0, bad = 0;
  int rx_cnt = 0, lost_cnt = 0, done_cnt = 0;
  logic [7:0] last_rx = '0;
  logic       last_perr = 1'b0;
  bit         finished = 1'b0;

  assign line = ~(line_drive_low | peer_low);

  always #10 clk = ~clk;

  cdu_node u_dut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .line_in(line), .line_drive_low(line_drive_low),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
    .lost_pulse(lost_pulse), .done_pulse(done_pulse)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rx_cnt++;
        last_rx   = rx_data;
        last_perr = rx_parity_err;
      end
      if (lost_pulse) lost_cnt++;
      if (done_pulse) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] frame_of(input logic [7:0] b, input bit flip);
    logic p;
    p = (^b) ^ flip;
    return {1'b1, p, b, 1'b0};
  endfunction

  // returns at the first negedge after the accepting edge (bit 0 start)
  task automatic launch(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic peer_frame(input logic [7:0] b, input bit flip);
    logic [10:0] f;
    f = frame_of(b, flip);
    for (int k = 0; k < 11; k++) begin
      peer_low = ~f[k];
      repeat (BIT) @(negedge clk);
    end
    peer_low = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(line_drive_low == 1'b0, "R11 line released", line_drive_low, 0);
    chk(!lost_pulse && !done_pulse && !rx_valid, "R11 pulses low",
        {lost_pulse, done_pulse, rx_valid}, 0);
    chk(tx_ready == 1'b1, "R11 ready", tx_ready, 1);
  endtask

  task automatic t_solo(input logic [7:0] b);
    logic [10:0] f;
    int d0, r0, w;
    f  = frame_of(b, 1'b0);
    d0 = done_cnt;
    r0 = rx_cnt;
    launch(b);
    for (int k = 0; k < 11; k++) begin
      repeat (k == 0 ? BIT/2 : BIT) @(negedge clk);
      chk(line == f[k], (k == 9) ? "R2 parity bit" : "R1 frame bit", line, f[k]);
    end
    w = 0;
    while (done_cnt == d0 && w < 40) begin @(negedge clk); w++; end
    chk(done_cnt == d0 + 1, "R3 done pulse", done_cnt - d0, 1);
    repeat (5) @(negedge clk);
    chk(tx_ready == 1'b0, "R10 ready held after frame", tx_ready, 0);
    repeat (30) @(negedge clk);
    chk(tx_ready == 1'b1, "R10 ready after idle", tx_ready, 1);
    chk(rx_cnt == r0 + 1 && last_rx == b, "R8 own frame received", last_rx, b);
    chk(last_perr == 1'b0, "R9 no parity error", last_perr, 0);
  endtask

  task automatic t_busy;
    int viol, r0;
    viol = 0;
    r0   = rx_cnt;
    fork
      peer_frame(8'h3C, 1'b0);
      begin
        repeat (20) @(negedge clk);
        tx_data  = 8'h55;
        tx_valid = 1'b1;
        for (int c = 20; c < 150; c++) begin
          @(negedge clk);
          if (tx_ready || line_drive_low) viol++;
        end
        tx_valid = 1'b0;
      end
    join
    chk(viol == 0, "R6 held off during foreign frame", viol, 0);
    repeat (40) @(negedge clk);
    chk(rx_cnt == r0 + 1 && last_rx == 8'h3C, "R8 foreign frame", last_rx, 8'h3C);
    chk(done_cnt >= 0 && line_drive_low == 1'b0, "R6 no drive", line_drive_low, 0);
  endtask

  task automatic t_parity_err;
    int r0;
    r0 = rx_cnt;
    peer_frame(8'h0F, 1'b1);
    repeat (40) @(negedge clk);
    chk(rx_cnt == r0 + 1 && last_rx == 8'h0F, "R9 data with bad parity", last_rx, 8'h0F);
    chk(last_perr == 1'b1, "R9 parity error flagged", last_perr, 1);
  endtask

  task automatic t_glitch;
    int r0;
    r0 = rx_cnt;
    @(negedge clk);
    peer_low = 1'b1;
    repeat (3) @(negedge clk);
    peer_low = 1'b0;
    repeat (40) @(negedge clk);
    chk(rx_cnt == r0, "R7 spike gives no byte", rx_cnt - r0, 0);
    chk(tx_ready == 1'b1, "R7 ready after spike", tx_ready, 1);
  endtask

  task automatic t_lose;
    int viol, l0, d0, r0;
    viol = 0;
    l0 = lost_cnt;
    d0 = done_cnt;
    r0 = rx_cnt;
    launch(8'h01);
    fork
      peer_frame(8'h00, 1'b0);
      begin
        repeat (BIT + 4) @(negedge clk);
        for (int c = 0; c < 150; c++) begin
          @(negedge clk);
          if (line_drive_low) viol++;
        end
      end
    join
    chk(lost_cnt == l0 + 1, "R4 lost pulse", lost_cnt - l0, 1);
    chk(viol == 0, "R4 released after loss", viol, 0);
    repeat (40) @(negedge clk);
    chk(done_cnt == d0, "R4 no done after loss", done_cnt - d0, 0);
    chk(rx_cnt == r0 + 1 && last_rx == 8'h00, "R8 winner frame received", last_rx, 0);
  endtask

  task automatic t_win;
    int l0, d0, r0;
    l0 = lost_cnt;
    d0 = done_cnt;
    r0 = rx_cnt;
    launch(8'h00);
    peer_frame(8'h01, 1'b0);
    repeat (40) @(negedge clk);
    chk(lost_cnt == l0, "R5 no loss when dominant", lost_cnt - l0, 0);
    chk(done_cnt == d0 + 1, "R5 frame completes", done_cnt - d0, 1);
    chk(rx_cnt == r0 + 1 && last_rx == 8'h00, "R5 line carries winner", last_rx, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_solo(8'hA6);
    t_solo(8'h07);
    repeat (20) @(negedge clk);
    t_busy();
    t_parity_err();
    t_glitch();
    t_lose();
    t_win();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule